// File: doc/BRIEF.md
# Processor Debug Observation Multiplexer

This block lets a handful of board switches choose which internal value of a single-cycle processor is shown on the board's indicators. It has two independent paths. The LED path picks a 16-bit word: one half of the instruction being executed, or a packed snapshot of the control strobes and flags. The display path picks one of twelve 32-bit datapath taps and keeps only its low 13 bits, which go to a decimal display driver.

The block is purely combinational. The processor presents its instruction, control strobes, flags and taps on dedicated ports, and the switches drive the two select inputs. The processor core, the binary-to-decimal converter and the segment driver are separate blocks.

The memory-read strobe also serves as the write-back source select. In the supported instruction subset the two are always equal, so the snapshot carries the strobe once and fits in 14 bits.

Top module: `obsMuxTop`

## Requirements
- R1: With `ledSel` = 2'b00, `ledOut` equals `instr[15:0]`.
- R2: With `ledSel` = 2'b01, `ledOut` equals `instr[31:16]`.
- R3: With `ledSel` = 2'b10, `ledOut[15:14]` is zero and `ledOut[13:0]` holds, from bit 13 down to bit 0: `branchOp[1:0]` (13:12), `memRd` (11), `memWr` (10), `aluSrc` (9), `regWr` (8), `aluOp[1:0]` (7:6), `aluSel[3:0]` (5:2), `zeroFlag` (1), `branchTaken` (0).
- R4: With `ledSel` = 2'b11, `ledOut` is all zeros.
- R5: `dispSel` codes 0 to 5 select, in that order, `pcCur`, `pcPlus4`, `brTarget`, `pcNext`, `rs1Data` and `rs2Data`.
- R6: `dispSel` codes 6 to 11 select, in that order, `rdData`, `immVal`, `immShl1`, `aluOpB`, `aluResult` and `memOut`.
- R7: `dispOut` is bits [12:0] of the selected tap. Bits [31:13] of every tap have no effect on `dispOut`.
- R8: `dispSel` codes 12 to 15 drive `dispOut` to zero.
- R9: `ledSel` has no effect on `dispOut`, and `dispSel` has no effect on `ledOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ledSel | input | 2 | LED word select |
| dispSel | input | 4 | Display tap select |
| instr | input | 32 | Instruction being executed |
| branchOp | input | 2 | Branch type strobe |
| memRd | input | 1 | Memory read / write-back source strobe |
| memWr | input | 1 | Memory write strobe |
| aluSrc | input | 1 | ALU second-operand source strobe |
| regWr | input | 1 | Register write strobe |
| aluOp | input | 2 | ALU operation class |
| aluSel | input | 4 | ALU function select lines |
| zeroFlag | input | 1 | ALU zero flag |
| branchTaken | input | 1 | Branch decision (AND gate result) |
| pcCur | input | 32 | Program counter |
| pcPlus4 | input | 32 | Sequential-address adder output |
| brTarget | input | 32 | Branch target adder output |
| pcNext | input | 32 | Program counter input |
| rs1Data | input | 32 | Register read data, first port |
| rs2Data | input | 32 | Register read data, second port |
| rdData | input | 32 | Register write data |
| immVal | input | 32 | Immediate generator output |
| immShl1 | input | 32 | Immediate shifted left by one |
| aluOpB | input | 32 | ALU second-operand mux output |
| aluResult | input | 32 | ALU result |
| memOut | input | 32 | Data memory output |
| ledOut | output | 16 | Selected LED word |
| dispOut | output | 13 | Low 13 bits of selected tap |

## Verification
The bench gives all twelve taps distinct values and all control strobes distinct values. A swapped tap order or a wrong snapshot bit position therefore shows as a mismatch instead of a coincidental match. Taps whose upper bits differ from their low bits catch a design that takes the wrong 13-bit slice. The unused codes (LED 11, display 12 to 15) are swept to catch a design that wraps or aliases them onto live taps. Each select is swept while the other is held, which exposes any cross-coupling between the two paths.

// File: rtl/obsMuxPkg.sv
package obsMuxPkg;
  localparam int XLEN      = 32;
  localparam int DISP_W    = 13;
  localparam int LED_W     = 16;
  localparam int NUM_TAPS  = 12;
  localparam int LSEL_W    = 2;
  localparam int DSEL_W    = 4;

  typedef struct packed {
    logic [1:0] branchOp;
    logic       memRd;
    logic       memWr;
    logic       aluSrc;
    logic       regWr;
    logic [1:0] aluOp;
    logic [3:0] aluSel;
    logic       zeroFlag;
    logic       branchTaken;
  } ctrlSnap_t;

  localparam int SNAP_W = $bits(ctrlSnap_t);

  typedef struct packed {
    logic [NUM_TAPS-1:0] tapHit;
    logic                ledLow;
    logic                ledHigh;
    logic                ledCtrl;
  } obsStrobe_t;
endpackage

// File: rtl/obsSelDecode.sv
module obsSelDecode
  import obsMuxPkg::*;
#(
  parameter int NTAP = NUM_TAPS,
  parameter int LSW  = LSEL_W,
  parameter int DSW  = DSEL_W
) (
  input  logic [LSW-1:0] ledSel,
  input  logic [DSW-1:0] dispSel,
  output obsStrobe_t     strb
);
  logic [NUM_TAPS-1:0] hitVec;

  generate
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_hit
      if (k < NTAP) begin : g_live
        assign hitVec[k] = (dispSel == DSW'(k));
      end else begin : g_dead
        assign hitVec[k] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    strb.tapHit  = hitVec;
    strb.ledLow  = (ledSel == LSW'(0));
    strb.ledHigh = (ledSel == LSW'(1));
    strb.ledCtrl = (ledSel == LSW'(2));
  end
endmodule

// File: rtl/obsLedPath.sv
module obsLedPath
  import obsMuxPkg::*;
#(
  parameter int IW = XLEN,
  parameter int LW = LED_W
) (
  input  obsStrobe_t     strb,
  input  logic [IW-1:0]  instr,
  input  ctrlSnap_t      snap,
  output logic [LW-1:0]  ledOut
);
  localparam int HALF = IW / 2;

  logic [LW-1:0] lowWord, highWord, ctrlWord;

  assign lowWord  = LW'(instr[HALF-1:0]);
  assign highWord = LW'(instr[IW-1:HALF]);
  assign ctrlWord = LW'(snap);

  always_comb begin
    ledOut = ({LW{strb.ledLow}}  & lowWord)
           | ({LW{strb.ledHigh}} & highWord)
           | ({LW{strb.ledCtrl}} & ctrlWord);
  end
endmodule

// File: rtl/obsTapPath.sv
module obsTapPath
  import obsMuxPkg::*;
#(
  parameter int W    = XLEN,
  parameter int DW   = DISP_W,
  parameter int NTAP = NUM_TAPS
) (
  input  obsStrobe_t                strb,
  input  logic [NTAP-1:0][W-1:0]    taps,
  output logic [DW-1:0]             dispOut
);
  logic [NTAP-1:0][DW-1:0] gated;

  generate
    for (genvar k = 0; k < NTAP; k++) begin : g_gate
      assign gated[k] = {DW{strb.tapHit[k]}} & taps[k][DW-1:0];
    end
  endgenerate

  always_comb begin
    dispOut = '0;
    for (int k = 0; k < NTAP; k++) dispOut |= gated[k];
  end
endmodule

// File: rtl/obsMuxTop.sv
module obsMuxTop
  import obsMuxPkg::*;
(
  input  logic [LSEL_W-1:0] ledSel,
  input  logic [DSEL_W-1:0] dispSel,
  input  logic [XLEN-1:0]   instr,
  input  logic [1:0]        branchOp,
  input  logic              memRd,
  input  logic              memWr,
  input  logic              aluSrc,
  input  logic              regWr,
  input  logic [1:0]        aluOp,
  input  logic [3:0]        aluSel,
  input  logic              zeroFlag,
  input  logic              branchTaken,
  input  logic [XLEN-1:0]   pcCur,
  input  logic [XLEN-1:0]   pcPlus4,
  input  logic [XLEN-1:0]   brTarget,
  input  logic [XLEN-1:0]   pcNext,
  input  logic [XLEN-1:0]   rs1Data,
  input  logic [XLEN-1:0]   rs2Data,
  input  logic [XLEN-1:0]   rdData,
  input  logic [XLEN-1:0]   immVal,
  input  logic [XLEN-1:0]   immShl1,
  input  logic [XLEN-1:0]   aluOpB,
  input  logic [XLEN-1:0]   aluResult,
  input  logic [XLEN-1:0]   memOut,
  output logic [LED_W-1:0]  ledOut,
  output logic [DISP_W-1:0] dispOut
);
  obsStrobe_t                      strb;
  ctrlSnap_t                       snap;
  logic [NUM_TAPS-1:0][XLEN-1:0]   tapBus;

  // tap order is the select code order
  assign tapBus[0]  = pcCur;
  assign tapBus[1]  = pcPlus4;
  assign tapBus[2]  = brTarget;
  assign tapBus[3]  = pcNext;
  assign tapBus[4]  = rs1Data;
  assign tapBus[5]  = rs2Data;
  assign tapBus[6]  = rdData;
  assign tapBus[7]  = immVal;
  assign tapBus[8]  = immShl1;
  assign tapBus[9]  = aluOpB;
  assign tapBus[10] = aluResult;
  assign tapBus[11] = memOut;

  always_comb begin
    snap.branchOp    = branchOp;
    snap.memRd       = memRd;
    snap.memWr       = memWr;
    snap.aluSrc      = aluSrc;
    snap.regWr       = regWr;
    snap.aluOp       = aluOp;
    snap.aluSel      = aluSel;
    snap.zeroFlag    = zeroFlag;
    snap.branchTaken = branchTaken;
  end

  obsSelDecode #(.NTAP(NUM_TAPS), .LSW(LSEL_W), .DSW(DSEL_W)) decode_i (
    .ledSel (ledSel),
    .dispSel(dispSel),
    .strb   (strb)
  );

  obsLedPath #(.IW(XLEN), .LW(LED_W)) ledPath_i (
    .strb  (strb),
    .instr (instr),
    .snap  (snap),
    .ledOut(ledOut)
  );

  obsTapPath #(.W(XLEN), .DW(DISP_W), .NTAP(NUM_TAPS)) tapPath_i (
    .strb   (strb),
    .taps   (tapBus),
    .dispOut(dispOut)
  );
endmodule

// File: rtl/obsMuxChecker.sv
module obsMuxChecker
  import obsMuxPkg::*;
(
  input logic [LSEL_W-1:0] ledSel,
  input logic [DSEL_W-1:0] dispSel,
  input logic [XLEN-1:0]   instr,
  input logic [1:0]        branchOp,
  input logic              branchTaken,
  input logic [XLEN-1:0]   pcCur,
  input logic [XLEN-1:0]   rs2Data,
  input logic [XLEN-1:0]   memOut,
  input logic [LED_W-1:0]  ledOut,
  input logic [DISP_W-1:0] dispOut
);
  always_comb begin
    if (ledSel == 2'b00) AST_LED_LOW_HALF: assert (ledOut == instr[15:0]); // R1
    if (ledSel == 2'b01) AST_LED_HIGH_HALF: assert (ledOut == instr[31:16]); // R2
    if (ledSel == 2'b10) AST_LED_SNAP_EDGES: assert (ledOut[15:14] == 2'b00 && ledOut[13:12] == branchOp && ledOut[0] == branchTaken); // R3
    if (ledSel == 2'b11) AST_LED_IDLE_ZERO: assert (ledOut == '0); // R4
    if (dispSel == 4'd0) AST_DISP_FIRST_TAP: assert (dispOut == pcCur[12:0]); // R5
    if (dispSel == 4'd5) AST_DISP_SIXTH_TAP: assert (dispOut == rs2Data[12:0]); // R5
    if (dispSel == 4'd11) AST_DISP_LAST_TAP: assert (dispOut == memOut[12:0]); // R6
    if (dispSel >= 4'd12) AST_DISP_IDLE_ZERO: assert (dispOut == '0); // R8
  end
endmodule

bind obsMuxTop obsMuxChecker checker_i (
  .ledSel     (ledSel),
  .dispSel    (dispSel),
  .instr      (instr),
  .branchOp   (branchOp),
  .branchTaken(branchTaken),
  .pcCur      (pcCur),
  .rs2Data    (rs2Data),
  .memOut     (memOut),
  .ledOut     (ledOut),
  .dispOut    (dispOut)
);

// File: tb/obsMuxTop_tb.sv
`timescale 1ns/1ps
module obsMuxTop_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  ledSel;
  logic [3:0]  dispSel;
  logic [31:0] instr;
  logic [1:0]  branchOp;
  logic        memRd, memWr, aluSrc, regWr;
  logic [1:0]  aluOp;
  logic [3:0]  aluSel;
  logic        zeroFlag, branchTaken;
  logic [31:0] tapArr [12];
  logic [15:0] ledOut;
  logic [12:0] dispOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  obsMuxTop dut_i (
    .ledSel(ledSel), .dispSel(dispSel), .instr(instr),
    .branchOp(branchOp), .memRd(memRd), .memWr(memWr), .aluSrc(aluSrc),
    .regWr(regWr), .aluOp(aluOp), .aluSel(aluSel), .zeroFlag(zeroFlag),
    .branchTaken(branchTaken),
    .pcCur(tapArr[0]), .pcPlus4(tapArr[1]), .brTarget(tapArr[2]),
    .pcNext(tapArr[3]), .rs1Data(tapArr[4]), .rs2Data(tapArr[5]),
    .rdData(tapArr[6]), .immVal(tapArr[7]), .immShl1(tapArr[8]),
    .aluOpB(tapArr[9]), .aluResult(tapArr[10]), .memOut(tapArr[11]),
    .ledOut(ledOut), .dispOut(dispOut)
  );

  function automatic logic [31:0] mix(int p, int k);
    logic [31:0] v;
    v = 32'(p * 16 + k + 1) * 32'h9E37_79B9;
    return v ^ (32'h0123_4567 << k) ^ 32'(k * 32'h0000_0111);
  endfunction

  task automatic loadPattern(int p);
    instr = mix(p, 20);
    {branchOp, memRd, memWr, aluSrc, regWr, aluOp, aluSel, zeroFlag, branchTaken}
      = 14'(mix(p, 30) >> 3);
    for (int k = 0; k < 12; k++) tapArr[k] = mix(p, k);
  endtask

  function automatic logic [15:0] expLed(logic [1:0] s);
    case (s)
      2'b00: return instr[15:0];
      2'b01: return instr[31:16];
      2'b10: return {2'b00, branchOp, memRd, memWr, aluSrc, regWr, aluOp, aluSel, zeroFlag, branchTaken};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [12:0] expDisp(logic [3:0] s);
    if (s < 4'd12) return tapArr[s][12:0];
    return 13'h0;
  endfunction

  function automatic string ledTag(logic [1:0] s);
    case (s)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic string dispTag(logic [3:0] s);
    if (s < 4'd6) return "R5";
    if (s < 4'd12) return "R6";
    return "R8";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (ledSel=%0d dispSel=%0d)", tag, act, exp, ledSel, dispSel);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] heldLed;
    logic [12:0] heldDisp;
    ledSel = 2'b11; dispSel = 4'd15;
    instr = '0;
    {branchOp, memRd, memWr, aluSrc, regWr, aluOp, aluSel, zeroFlag, branchTaken} = '0;
    for (int k = 0; k < 12; k++) tapArr[k] = '0;
    @(negedge clk);
    // idle state: all-zero inputs, unused codes
    check("R4", ledOut, 16'h0);
    check("R8", {3'b0, dispOut}, 16'h0);

    // full sweep over patterns and both selects
    for (int p = 0; p < 8; p++) begin
      @(posedge clk);
      loadPattern(p);
      for (int l = 0; l < 4; l++) begin
        for (int d = 0; d < 16; d++) begin
          @(posedge clk);
          ledSel = 2'(l); dispSel = 4'(d);
          @(negedge clk);
          check(ledTag(2'(l)), ledOut, expLed(2'(l)));
          check(dispTag(4'(d)), {3'b0, dispOut}, {3'b0, expDisp(4'(d))});
        end
      end
    end

    // R7: upper tap bits flipped, low bits kept: display unchanged
    for (int d = 0; d < 12; d++) begin
      @(posedge clk);
      loadPattern(3);
      ledSel = 2'b00; dispSel = 4'(d);
      @(negedge clk);
      heldDisp = dispOut;
      @(posedge clk);
      for (int k = 0; k < 12; k++) tapArr[k] = tapArr[k] ^ 32'hFFFF_E000;
      @(negedge clk);
      check("R7", {3'b0, dispOut}, {3'b0, heldDisp});
      check("R7", {3'b0, dispOut}, {3'b0, mix(3, d) & 13'h1FFF});
    end

    // R9: each select swept while the other output is held
    @(posedge clk);
    loadPattern(5);
    dispSel = 4'd9; ledSel = 2'b00;
    @(negedge clk);
    heldDisp = dispOut;
    for (int l = 1; l < 4; l++) begin
      @(posedge clk); ledSel = 2'(l);
      @(negedge clk);
      check("R9", {3'b0, dispOut}, {3'b0, heldDisp});
    end
    @(posedge clk); ledSel = 2'b10; dispSel = 4'd0;
    @(negedge clk);
    heldLed = ledOut;
    for (int d = 1; d < 16; d++) begin
      @(posedge clk); dispSel = 4'(d);
      @(negedge clk);
      check("R9", ledOut, heldLed);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule